// File: doc/BRIEF.md
# Single-Channel Memory Transfer Engine

This block is one channel of a memory-to-memory transfer engine. Software writes a source address, a destination address, a transfer count and a control word. A transfer then starts on a hardware trigger pulse or on a software request bit in the control word. Each transfer reads one item from the source address and writes it to the destination address. The two addresses then step on their own: each can hold, increment or decrement, by 1 for bytes or 2 for 16-bit words.

Transfers run either one per trigger or as a whole block per trigger, and each of these can be made repeating. When the count runs out, the engine does three things:
- It pulses a done output.
- It restores the addresses and count, if the reload bit or a repeating mode asks for it. The starting addresses are rebuilt from the saved starting count, so only the count is kept as a copy.
- It clears its own enable if the mode does not repeat.

An optional null-write follows every destination write with a write of zero to the source address.

Top module: `dma_chan_engine`

## Requirements
- R1: Configuration writes use `cfg_sel`: 0 is the control word, 1 the source address, 2 the destination address and 3 the count. Control bit 0 is the enable. While it is 0, `hw_trig` and the software request start nothing, and `sw_pend` stays 0.
- R2: Control bits 7:6 set the source address mode and bits 5:4 the destination mode. After each transfer, code 00 holds the address, 01 adds the step, 10 subtracts it and 11 holds it.
- R3: Control bit 1 selects the size. With 1 the step is 1 and `mem_byte` is 1. With 0 the step is 2 and `mem_byte` is 0.
- R4: A transfer reads the source address, then writes the read data to the destination address. When control bit 10 (null-write) is 1, a write of zero to the source address follows every destination write.
- R5: Control bits 3:2 set the transfer mode. Bit 3 = 0 gives one transfer per accepted trigger. Bit 3 = 1 gives the whole remaining block on one trigger. Bit 2 = 1 makes the mode repeating.
- R6: The count drops by one per transfer. The transfer that takes it to zero causes a one-cycle `blk_done` pulse. Triggers are ignored while the count is zero.
- R7: At block completion in a non-repeating mode, the engine clears its enable (`chan_on` goes to 0). A repeating mode stays enabled.
- R8: With control bit 9 (reload) set, block completion restores the starting source, destination and count. The addresses are rebuilt from the saved starting count. With the bit clear, nothing is restored.
- R9: In the repeating modes, the restore of R8 always happens, whatever bit 9 holds.
- R10: Control bit 8 is a software request. With the enable set, it starts work without `hw_trig`, and `sw_pend` shows it pending. It clears when the engine goes idle, which is after one transfer in the one-per-trigger modes and after the whole block otherwise.
- R11: `mem_req` stays high, with address, write flag and write data stable, until the cycle in which `mem_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 source, 2 destination, 3 count |
| cfg_wdata | input | AW | Configuration write data |
| hw_trig | input | 1 | Hardware trigger pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access, 0 = read |
| mem_byte | output | 1 | 1 = byte access, 0 = 16-bit word |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access acknowledge |
| blk_done | output | 1 | One-cycle block completion pulse |
| chan_on | output | 1 | Current enable state |
| sw_pend | output | 1 | Software request pending |

## Verification
The bench attacks the restore path with every mix of address modes, including decrement across zero. A design that rebuilt an address with the wrong sign or the wrong step would replay the second block from the wrong addresses. It also checks that the count is not restored when neither reload nor repeat applies. A wrong design would move data again after re-enable, where a trigger should be ignored. The null-write ordering, the split between one transfer and a whole block per trigger, and the drop of the enable at the end of non-repeating modes are all compared against a bench-side access log. A faulty design would show extra, missing or reordered accesses, or a wrong `chan_on`.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          hw_trig,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_byte,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          blk_done,
  output logic          chan_on,
  output logic          sw_pend
);
  typedef enum logic [1:0] {IDLE, RD, WR, NW} st_t;
  st_t st;

  logic en, bsz, rld, nullw, swr, done_q;
  logic [1:0] tmode, smode, dmode;
  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt, cnt0;
  logic [DW-1:0] buf_q;

  function automatic logic [AW-1:0] fwd(input logic [AW-1:0] a, input logic [1:0] m,
                                        input logic [AW-1:0] d);
    case (m)
      2'b01:   return a + d;
      2'b10:   return a - d;
      default: return a;
    endcase
  endfunction

  function automatic logic [AW-1:0] back(input logic [AW-1:0] a, input logic [1:0] m,
                                         input logic [AW-1:0] d);
    case (m)
      2'b01:   return a - d;
      2'b10:   return a + d;
      default: return a;
    endcase
  endfunction

  wire [AW-1:0] step    = bsz ? AW'(1) : AW'(2);
  wire [AW-1:0] span    = bsz ? AW'(cnt0) : AW'({cnt0, 1'b0});
  wire          go      = (st == IDLE) && en && (cnt != '0) && (hw_trig || swr);
  wire          last_ph = mem_ack && ((st == WR && !nullw) || st == NW);
  wire          blk_end = last_ph && (cnt == CW'(1));
  wire          rebuild = blk_end && (tmode[0] || rld);
  wire [AW-1:0] src_nx  = fwd(src, smode, step);
  wire [AW-1:0] dst_nx  = fwd(dst, dmode, step);

  assign mem_req   = (st != IDLE);
  assign mem_we    = (st == WR) || (st == NW);
  assign mem_byte  = bsz;
  assign mem_addr  = (st == WR) ? dst : src;
  assign mem_wdata = (st == WR) ? buf_q : '0;
  assign blk_done  = done_q;
  assign chan_on   = en;
  assign sw_pend   = swr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      en     <= 1'b0;
      bsz    <= 1'b0;
      rld    <= 1'b0;
      nullw  <= 1'b0;
      swr    <= 1'b0;
      tmode  <= '0;
      smode  <= '0;
      dmode  <= '0;
      src    <= '0;
      dst    <= '0;
      cnt    <= '0;
      cnt0   <= '0;
      buf_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: begin
            en    <= cfg_wdata[0];
            bsz   <= cfg_wdata[1];
            tmode <= cfg_wdata[3:2];
            dmode <= cfg_wdata[5:4];
            smode <= cfg_wdata[7:6];
            swr   <= cfg_wdata[8] & cfg_wdata[0];
            rld   <= cfg_wdata[9];
            nullw <= cfg_wdata[10];
          end
          2'd1: src <= cfg_wdata;
          2'd2: dst <= cfg_wdata;
          default: begin
            cnt  <= cfg_wdata[CW-1:0];
            cnt0 <= cfg_wdata[CW-1:0];
          end
        endcase
      end
      case (st)
        IDLE: if (go) st <= RD;
        RD: if (mem_ack) begin
          buf_q <= mem_rdata;
          st    <= WR;
        end
        WR: if (mem_ack && nullw) st <= NW;
        default: ;
      endcase
      if (last_ph) begin
        src <= rebuild ? back(src_nx, smode, span) : src_nx;
        dst <= rebuild ? back(dst_nx, dmode, span) : dst_nx;
        cnt <= rebuild ? cnt0 : cnt - CW'(1);
        if (blk_end) begin
          done_q <= 1'b1;
          st     <= IDLE;
          swr    <= 1'b0;
          if (!tmode[0]) en <= 1'b0;
        end else if (tmode[1]) begin
          st <= RD;
        end else begin
          st  <= IDLE;
          swr <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          blk_done,
  input logic          chan_on,
  input logic          sw_pend
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> !mem_req);

  a_r10_sw_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pend |-> chan_on);

  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_on && !mem_req |=> !mem_req);
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .blk_done(blk_done),
  .chan_on(chan_on), .sw_pend(sw_pend)
);

// File: tb/dma_chan_engine_tb_top.sv
module dma_chan_engine_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic hw_trig = 1'b0;
  logic mem_req, mem_we, mem_byte, blk_done, chan_on, sw_pend;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic mem_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int done_total = 0;
  int wait_cnt = 0;
  logic [33:0] log_q[$];
  logic [33:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  dma_chan_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .hw_trig(hw_trig), .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .blk_done(blk_done), .chan_on(chan_on), .sw_pend(sw_pend)
  );

  function automatic logic [15:0] pat(input logic [15:0] a);
    logic [15:0] r;
    r = a * 16'h9E37;
    return r ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] badv(input logic [15:0] a, input logic [1:0] m, input logic b);
    logic [15:0] s;
    s = b ? 16'd1 : 16'd2;
    case (m)
      2'b01:   return a + s;
      2'b10:   return a - s;
      default: return a;
    endcase
  endfunction

  function automatic logic [15:0] cw(input logic e, input logic b, input logic [1:0] tm,
                                     input logic [1:0] dm, input logic [1:0] sm,
                                     input logic sw, input logic rl, input logic nw);
    return {5'd0, nw, rl, sw, sm, dm, tm, b, e};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        log_q.push_back({mem_we, mem_byte, mem_addr, mem_we ? mem_wdata : 16'h0});
        mem_rdata = pat(mem_addr);
        mem_ack = 1'b1;
        wait_cnt = $urandom % 3;
      end else begin
        wait_cnt = wait_cnt - 1;
      end
    end
  end

  always @(negedge clk) if (rst_n && blk_done) done_total++;

  task automatic chk(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic trig();
    @(negedge clk);
    hw_trig = 1'b1;
    @(negedge clk);
    hw_trig = 1'b0;
  endtask

  task automatic exp_block(input logic [15:0] s0, input logic [15:0] d0, input int n,
                           input logic [1:0] sm, input logic [1:0] dm, input logic b, input logic nw);
    logic [15:0] s, d;
    s = s0; d = d0;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({1'b0, b, s, 16'h0});
      exp_q.push_back({1'b1, b, d, pat(s)});
      if (nw) exp_q.push_back({1'b1, b, s, 16'h0});
      s = badv(s, sm, b);
      d = badv(d, dm, b);
    end
  endtask

  task automatic compare(input int base, input string tag);
    chk(log_q.size() - base == exp_q.size(), {tag, " access count"},
        34'(log_q.size() - base), 34'(exp_q.size()));
    for (int i = 0; i < exp_q.size(); i++)
      if (base + i < log_q.size())
        chk(log_q[base + i] == exp_q[i], tag, log_q[base + i], exp_q[i]);
    exp_q.delete();
  endtask

  task automatic run_block(input logic [1:0] tm, input int n);
    if (tm[1]) begin
      trig();
      repeat (n * 20 + 10) @(negedge clk);
    end else begin
      for (int i = 0; i < n; i++) begin
        trig();
        repeat (20) @(negedge clk);
      end
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    int base, d0;
    logic [1:0] sm, dm, tm;
    logic b, rl, nw;
    logic [15:0] s, d;
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({mem_req, blk_done, chan_on, sw_pend} == 4'b0, "reset R11", 34'({mem_req, blk_done, chan_on, sw_pend}), 34'd0);

    // R1: disabled channel ignores software request and trigger
    base = log_q.size();
    wr(2'd1, 16'h0100); wr(2'd2, 16'h0200); wr(2'd3, 16'd3);
    wr(2'd0, cw(1'b0, 1'b0, 2'b10, 2'b01, 2'b01, 1'b1, 1'b0, 1'b0));
    chk(sw_pend == 1'b0, "R1 sw_pend while disabled", 34'(sw_pend), 34'd0);
    trig();
    repeat (40) @(negedge clk);
    chk(log_q.size() == base, "R1 no access while disabled", 34'(log_q.size() - base), 34'd0);

    // R10: software request, one-shot then continuous
    base = log_q.size();
    wr(2'd0, cw(1'b1, 1'b0, 2'b00, 2'b01, 2'b01, 1'b1, 1'b0, 1'b0));
    repeat (30) @(negedge clk);
    exp_block(16'h0100, 16'h0200, 1, 2'b01, 2'b01, 1'b0, 1'b0);
    compare(base, "R10 one-shot sw request");
    chk(sw_pend == 1'b0, "R10 request cleared", 34'(sw_pend), 34'd0);
    base = log_q.size();
    wr(2'd1, 16'h0300); wr(2'd2, 16'h0400); wr(2'd3, 16'd4);
    wr(2'd0, cw(1'b1, 1'b1, 2'b10, 2'b10, 2'b01, 1'b1, 1'b0, 1'b1));
    repeat (120) @(negedge clk);
    exp_block(16'h0300, 16'h0400, 4, 2'b01, 2'b10, 1'b1, 1'b1);
    compare(base, "R10 R4 continuous sw request");
    chk(mem_req == 1'b0, "R11 idle after block", 34'(mem_req), 34'd0);

    // random mix of modes, sizes, reload and null-write
    for (int k = 0; k < 40; k++) begin
      sm = 2'($urandom % 4); dm = 2'($urandom % 4); tm = 2'($urandom % 4);
      b = 1'($urandom % 2); rl = 1'($urandom % 2); nw = 1'($urandom % 2);
      n = 1 + ($urandom % 5);
      s = (k < 4) ? 16'h0002 : 16'($urandom);
      d = (k < 4) ? 16'hFFFE : 16'($urandom);
      wr(2'd1, s); wr(2'd2, d); wr(2'd3, 16'(n));
      wr(2'd0, cw(1'b1, b, tm, dm, sm, 1'b0, rl, nw));
      base = log_q.size(); d0 = done_total;
      run_block(tm, n);
      exp_block(s, d, n, sm, dm, b, nw);
      compare(base, "R2 R3 R4 R5 first block");
      chk(done_total - d0 == 1, "R6 one done per block", 34'(done_total - d0), 34'd1);
      chk(chan_on == tm[0], "R7 enable after block", 34'(chan_on), 34'(tm[0]));
      if (!tm[0]) wr(2'd0, cw(1'b1, b, tm, dm, sm, 1'b0, rl, nw));
      base = log_q.size();
      if (tm[0] || rl) begin
        run_block(tm, n);
        exp_block(s, d, n, sm, dm, b, nw);
        compare(base, tm[0] ? "R9 repeat restores" : "R8 reload restores");
      end else begin
        trig();
        repeat (30) @(negedge clk);
        chk(log_q.size() == base, "R8 R6 no restore, zero count ignored",
            34'(log_q.size() - base), 34'd0);
      end
    end
    finish_up();
  end
endmodule